// File: doc/BRIEF.md
# Encoder Velocity Capture Unit

This block measures how fast an encoder turns. It counts one-cycle encoder clock strobes over a fixed time window. A down-timer sets the length of the window and restarts from a reload value each time it expires. When the timer runs out, three things happen in the same clock edge:

- the pulse total for the finished window is copied into a capture register;
- the live pulse counter restarts;
- the timer reloads.

Each captured total is then compared with a threshold. A one-cycle event is raised when the total is strictly below that threshold.

The control is a two-state machine:

- `ST_ARM` is entered on reset. It loads the timer, restarts the counter and moves on.
- `ST_RUN` counts. It has three transitions:
  - *tick*: timer not zero, so the timer decrements and strobes are counted.
  - *expire*: timer at zero, so the unit captures, restarts and reloads.
  - *flush*: velocity clear asserted, so the unit restarts and reloads without capturing.
- `ST_ARM` takes the single transition *arm* to `ST_RUN`.

A software layer that turns captured totals into shaft speed sits outside this unit.

Top module: `enc_vel_unit`

## Requirements
- R1: During reset and in the first cycle after it, the timer, the live count, the captured value and both event outputs read 0. The first clock edge after reset loads the timer from the reload input.
- R2: While running, the timer falls by one per cycle. In the cycle after it reads 0, it shows the reload value and `tmr_ovf` is high for exactly that cycle. A window therefore lasts reload+1 cycles.
- R3: At each expiry, `vel_cap` takes the number of strobes counted during the window that just ended.
- R4: Every cycle with `enc_pulse` high inside a window raises `vel_live` by one.
- R5: `cap_below` is high in the same cycle as `tmr_ovf` when the captured total is strictly less than `cmp_val`. An equal or larger total gives no event.
- R6: `vel_clr` reloads the timer and restarts the live count. It leaves `vel_cap` unchanged and raises no event. It wins over an expiry in the same cycle.
- R7: A strobe that arrives in an expiry, clear or arm cycle is counted in the new window, so `vel_live` reads 1 afterwards.
- R8: `vel_live` saturates at its all-ones value and does not wrap.
- R9: The reload input is sampled only when the timer loads. A change in the middle of a window does not disturb the running timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_pulse | input | 1 | One-cycle encoder clock strobe |
| vel_clr | input | 1 | Velocity clear strobe |
| reload_val | input | TMR_W | Timer reload value |
| cmp_val | input | CNT_W | Velocity threshold |
| timer_q | output | TMR_W | Running window timer |
| vel_live | output | CNT_W | Strobes counted in the current window |
| vel_cap | output | CNT_W | Total captured at the last expiry |
| tmr_ovf | output | 1 | One-cycle timer expiry event |
| cap_below | output | 1 | One-cycle event: capture below threshold |

## Verification
The assertions assume that `enc_pulse` and `vel_clr` are synchronous to `clk` and are sampled as plain levels. They also assume that `reload_val` and `cmp_val` are stable at the edge where the unit uses them. The bench drives every input on the falling edge, so each value is settled before the next rising edge.

The bench sweeps small reload values, strobe spacings and thresholds. It places clears at arbitrary points, including the expiry cycle. A narrow 4-bit count makes the saturation case reachable within a short run.

// File: rtl/enc_vel_pkg.sv
package enc_vel_pkg;
    typedef enum logic {
        ST_ARM = 1'b0,
        ST_RUN = 1'b1
    } vel_state_t;
endpackage

// File: rtl/enc_vel_timer.sv
module enc_vel_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [TMR_W-1:0] load_val,
    output logic [TMR_W-1:0] q,
    output logic             zero
);
    localparam logic [TMR_W-1:0] ONE = {{(TMR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (dec)  q <= q - ONE;
    end

    assign zero = (q == '0);

    // R9
    load_takes_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(load_val));

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> q == $past(q) - ONE);
endmodule

// File: rtl/enc_vel_counter.sv
module enc_vel_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (restart)               cnt <= inc ? ONE : '0;
        else if (inc && cnt != CMAX)    cnt <= cnt + ONE;
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && !restart) |=> cnt == CMAX);

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !restart && cnt != CMAX) |=> cnt == $past(cnt) + ONE);

    // R7
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && inc) |=> cnt == ONE);
endmodule

// File: rtl/enc_vel_ctrl.sv
module enc_vel_ctrl
    import enc_vel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_zero,
    input  logic clr,
    output logic do_load,
    output logic do_dec,
    output logic do_capture
);
    vel_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARM;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        do_load    = 1'b0;
        do_dec     = 1'b0;
        do_capture = 1'b0;
        unique case (state)
            ST_ARM: begin
                do_load  = 1'b1;
                state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (clr) begin
                    do_load = 1'b1;
                end else if (tmr_zero) begin
                    do_load    = 1'b1;
                    do_capture = 1'b1;
                end else begin
                    do_dec = 1'b1;
                end
            end
            default: state_nx = ST_ARM;
        endcase
    end

    // R6
    clr_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !do_capture);

    // R2
    expire_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tmr_zero && !clr) |-> do_capture);
endmodule

// File: rtl/enc_vel_unit.sv
module enc_vel_unit #(
    parameter int TMR_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_pulse,
    input  logic             vel_clr,
    input  logic [TMR_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [TMR_W-1:0] timer_q,
    output logic [CNT_W-1:0] vel_live,
    output logic [CNT_W-1:0] vel_cap,
    output logic             tmr_ovf,
    output logic             cap_below
);
    logic tmr_zero, do_load, do_dec, do_capture;

    enc_vel_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_zero   (tmr_zero),
        .clr        (vel_clr),
        .do_load    (do_load),
        .do_dec     (do_dec),
        .do_capture (do_capture)
    );

    enc_vel_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .dec      (do_dec),
        .load_val (reload_val),
        .q        (timer_q),
        .zero     (tmr_zero)
    );

    enc_vel_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_load),
        .inc     (enc_pulse),
        .cnt     (vel_live)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vel_cap   <= '0;
            tmr_ovf   <= 1'b0;
            cap_below <= 1'b0;
        end else begin
            tmr_ovf   <= do_capture;
            cap_below <= do_capture && (vel_live < cmp_val);
            if (do_capture) vel_cap <= vel_live;
        end
    end

    // R5
    below_with_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_below |-> tmr_ovf);

    // R6
    clr_keeps_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vel_clr |=> $stable(vel_cap) && !tmr_ovf);

    // R3
    cap_takes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_capture |=> vel_cap == $past(vel_live));

    // R2
    ovf_shows_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |-> timer_q == $past(reload_val));
endmodule

// File: tb/tb_enc_vel_unit.sv
module tb_enc_vel_unit;
    localparam int TW = 8;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_pulse = 1'b0;
    logic vel_clr = 1'b0;
    logic [TW-1:0] reload_val = '0;
    logic [CW-1:0] cmp_val = '0;
    logic [TW-1:0] timer_q;
    logic [CW-1:0] vel_live, vel_cap;
    logic tmr_ovf, cap_below;

    int total = 0;
    int bad = 0;
    int m_armed, m_tmr, m_cnt, m_cap, m_ovf, m_below;

    always #5 clk = ~clk;

    enc_vel_unit #(.TMR_W(TW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .enc_pulse(enc_pulse), .vel_clr(vel_clr),
        .reload_val(reload_val), .cmp_val(cmp_val), .timer_q(timer_q),
        .vel_live(vel_live), .vel_cap(vel_cap), .tmr_ovf(tmr_ovf),
        .cap_below(cap_below)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R2 timer", int'(timer_q), m_tmr);
        chk("R2 ovf", int'(tmr_ovf), m_ovf);
        chk("R4 live", int'(vel_live), m_cnt);
        chk("R3 cap", int'(vel_cap), m_cap);
        chk("R5 below", int'(cap_below), m_below);
    endtask

    // Called at a falling edge; advances one cycle and compares at the next falling edge.
    task automatic step(input logic p, input logic c);
        enc_pulse = p;
        vel_clr = c;
        m_ovf = 0;
        m_below = 0;
        if (m_armed == 0 || c) begin
            m_armed = 1;
            m_tmr = int'(reload_val);
            m_cnt = p ? 1 : 0;
        end else if (m_tmr == 0) begin
            m_cap = m_cnt;
            m_below = (m_cnt < int'(cmp_val)) ? 1 : 0;
            m_ovf = 1;
            m_cnt = p ? 1 : 0;
            m_tmr = int'(reload_val);
        end else begin
            m_tmr = m_tmr - 1;
            if (p && m_cnt < CMAX) m_cnt = m_cnt + 1;
        end
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic do_reset();
        rst_n = 0;
        enc_pulse = 0;
        vel_clr = 0;
        repeat (3) @(negedge clk);
        m_armed = 0; m_tmr = 0; m_cnt = 0; m_cap = 0; m_ovf = 0; m_below = 0;
        // R1
        chk("R1 timer", int'(timer_q), 0);
        chk("R1 live", int'(vel_live), 0);
        chk("R1 cap", int'(vel_cap), 0);
        chk("R1 events", int'({tmr_ovf, cap_below}), 0);
        rst_n = 1;
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        reload_val = 8'd3;
        do_reset();
        step(0, 0);
        // R1: first edge after reset loads the timer
        chk("R1 load", int'(timer_q), 3);

        // Sweep reload, strobe spacing and threshold (R2 R3 R4 R5)
        for (int r = 0; r < 5; r++) begin
            for (int k = 1; k <= 3; k++) begin
                for (int t = 0; t < 4; t++) begin
                    reload_val = TW'(r);
                    cmp_val = CW'(t);
                    do_reset();
                    for (int cyc = 0; cyc < 16; cyc++)
                        step((cyc % k) == 0, 0);
                end
            end
        end

        // R7: strobe in the expiry cycle counts in the new window
        reload_val = 8'd3;
        cmp_val = 4'd0;
        do_reset();
        step(0, 0);
        while (m_tmr != 0) step(1, 0);
        step(1, 0);
        chk("R7 live", int'(vel_live), 1);
        chk("R7 ovf", int'(tmr_ovf), 1);

        // R6: clear mid window keeps capture, reloads timer
        begin
            int held;
            step(1, 0);
            step(1, 0);
            held = int'(vel_cap);
            step(0, 1);
            chk("R6 cap", int'(vel_cap), held);
            chk("R6 timer", int'(timer_q), 3);
            chk("R6 live", int'(vel_live), 0);
            chk("R6 ovf", int'(tmr_ovf), 0);
            // clear in the expiry cycle wins
            while (m_tmr != 0) step(1, 0);
            held = int'(vel_cap);
            step(0, 1);
            chk("R6 prio cap", int'(vel_cap), held);
            chk("R6 prio ovf", int'(tmr_ovf), 0);
        end

        // R9: reload change mid window does not disturb the running timer
        reload_val = 8'd10;
        do_reset();
        step(0, 0);
        step(0, 0);
        reload_val = 8'd50;
        step(0, 0);
        chk("R9 timer", int'(timer_q), 8);
        while (m_tmr != 0) step(0, 0);
        step(0, 0);
        chk("R9 reload", int'(timer_q), 50);

        // R8: saturation of the live count
        reload_val = 8'd40;
        cmp_val = 4'd15;
        do_reset();
        for (int i = 0; i < 30; i++) step(1, 0);
        chk("R8 live", int'(vel_live), CMAX);
        while (m_tmr != 0) step(1, 0);
        step(0, 0);
        chk("R8 cap", int'(vel_cap), CMAX);
        chk("R5 equal no event", int'(cap_below), 0);

        // Random clears over a short window
        reload_val = 8'd2;
        cmp_val = 4'd2;
        do_reset();
        for (int i = 0; i < 60; i++)
            step((i % 2) == 1, (i % 7) == 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule